// File: doc/BRIEF.md
# Real-Time Clock Event Flags and Interrupt Combiner

This block sits beside a real-time clock and turns its event pulses into software-visible status. It watches three sources: a strobe that marks the end of a time-register update, a strobe that marks an alarm match, and the level of one selected divider tap. Each source sets a sticky flag. Each flag is gated by its own enable input, and the gated flags are ORed onto one interrupt line. A read-only status byte shows the interrupt state and the three flags. Reading the status byte clears the flags, and that drops the interrupt.

A second read-only byte reports supply health. Its top bit drops to 0 as soon as the low-voltage sense input is seen high. It stays at 0 until that byte is read, and the read loads it from the present sense level. While this bit reads 0, the alarm flag is held clear. A software reset of the clock, or the clock being disabled, holds the update and periodic flags clear.

Top module: `rtc_irq_flags`

## Requirements
- R1: After rst_ni is released with no stimulus, stat_o is 8'h00, pwr_o is 8'h80 and irq_o is 0.
- R2: An upd_evt_i pulse sets the update flag, stat_o bit 4, from the next cycle onward.
- R3: An alm_evt_i pulse sets the alarm flag, stat_o bit 5, from the next cycle onward, provided pwr_o bit 7 is 1.
- R4: Any change in the level of tap_i, rising or falling, sets the periodic flag, stat_o bit 6, from the next cycle onward.
- R5: irq_o equals (upd_en_i & bit 4) | (alm_en_i & bit 5) | (per_en_i & bit 6) of stat_o, and stat_o bit 7 always equals irq_o.
- R6: A cycle with rd_stat_i high clears bits 4, 5 and 6 of stat_o from the next cycle, and irq_o falls with them.
- R7: When an event arrives in the same cycle as rd_stat_i, that event's flag is set after the read.
- R8: While soft_rst_i or clk_dis_i is high, bits 4 and 6 are cleared and cannot set. Bit 5 is not affected by these inputs.
- R9: A cycle with vlow_i high forces pwr_o bit 7 to 0 from the next cycle. The bit stays 0 after vlow_i falls, until a read.
- R10: A cycle with rd_pwr_i high loads pwr_o bit 7 with the inverse of vlow_i sampled in that cycle.
- R11: While pwr_o bit 7 is 0, stat_o bit 5 is 0, and alarm strobes have no effect.
- R12: stat_o bits 3:0 and pwr_o bits 6:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| soft_rst_i | input | 1 | Software reset of the clock |
| clk_dis_i | input | 1 | Clock disabled |
| upd_evt_i | input | 1 | Time-update-ended strobe |
| alm_evt_i | input | 1 | Alarm-match strobe |
| tap_i | input | 1 | Level of the selected divider tap |
| upd_en_i | input | 1 | Update interrupt enable |
| alm_en_i | input | 1 | Alarm interrupt enable |
| per_en_i | input | 1 | Periodic interrupt enable |
| vlow_i | input | 1 | Supply-low sense |
| rd_stat_i | input | 1 | Status byte read strobe |
| rd_pwr_i | input | 1 | Supply byte read strobe |
| irq_o | output | 1 | Interrupt line |
| stat_o | output | 8 | Status byte: irq, periodic, alarm, update flags |
| pwr_o | output | 8 | Supply byte: valid bit in bit 7 |

## Verification
The enables are stepped through several combinations, each with a different set of flags pending. This shows whether each enable gates its own flag and not a neighbour's. The tap is toggled in both directions, and a steady high level is held across a read. This separates detecting changes from following the level. Events that land in the same cycle as a read, and events held off by the clock being reset or disabled, show which of set and clear takes priority. Driving the sense input high and low around reads of the supply byte shows the difference between a sticky bit and re-arming on a read, and shows the alarm being held off by the supply bit.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned N_SRC   = 3;
  // source index order inside the flag vector
  localparam int unsigned SRC_UPD = 0;
  localparam int unsigned SRC_ALM = 1;
  localparam int unsigned SRC_PER = 2;
  // status byte layout
  localparam int unsigned FLAG_LSB = 4;
  localparam int unsigned IRQ_BIT  = REG_W - 1;
  localparam int unsigned VLD_BIT  = REG_W - 1;
endpackage

// File: rtl/rtc_evt_flag.sv
module rtc_evt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic rd_i,
  input  logic hold_clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (hold_clr_i) flag_q <= 1'b0;
    else                 flag_q <= evt_i | (flag_q & ~rd_i);
  end

  assign flag_o = flag_q;

  assert_hold_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_clr_i |=> !flag_o);
  assert_evt_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !hold_clr_i) |=> flag_o);
  assert_rd_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !evt_i) |=> !flag_o);
endmodule

// File: rtl/rtc_supply_mon.sv
module rtc_supply_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vlow_i,
  input  logic rd_i,
  output logic low_next_o,
  output logic low_seen_o
);
  logic low_q, low_d;

  // a read re-arms the sticky bit to the present sense level
  assign low_d = rd_i ? vlow_i : (low_q | vlow_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_q <= 1'b0;
    else         low_q <= low_d;
  end

  assign low_next_o = low_d;
  assign low_seen_o = low_q;

  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_seen_o && !rd_i) |=> low_seen_o);
  assert_rearm_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !vlow_i) |=> !low_seen_o);
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             clk_dis_i,
  input  logic             upd_evt_i,
  input  logic             alm_evt_i,
  input  logic             tap_i,
  input  logic             upd_en_i,
  input  logic             alm_en_i,
  input  logic             per_en_i,
  input  logic             vlow_i,
  input  logic             rd_stat_i,
  input  logic             rd_pwr_i,
  output logic             irq_o,
  output logic [REG_W-1:0] stat_o,
  output logic [REG_W-1:0] pwr_o
);
  logic             tap_q;
  logic             low_next, low_seen;
  logic [N_SRC-1:0] evt, hold_clr, en, flag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_q <= 1'b0;
    else         tap_q <= tap_i;
  end

  rtc_supply_mon u_supply (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vlow_i     (vlow_i),
    .rd_i       (rd_pwr_i),
    .low_next_o (low_next),
    .low_seen_o (low_seen)
  );

  always_comb begin
    evt               = '0;
    hold_clr          = '0;
    en                = '0;
    evt[SRC_UPD]      = upd_evt_i;
    evt[SRC_ALM]      = alm_evt_i;
    evt[SRC_PER]      = tap_i ^ tap_q;
    hold_clr[SRC_UPD] = soft_rst_i | clk_dis_i;
    hold_clr[SRC_PER] = soft_rst_i | clk_dis_i;
    hold_clr[SRC_ALM] = low_next;
    en[SRC_UPD]       = upd_en_i;
    en[SRC_ALM]       = alm_en_i;
    en[SRC_PER]       = per_en_i;
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_flag
    rtc_evt_flag u_flag (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt[g]),
      .rd_i       (rd_stat_i),
      .hold_clr_i (hold_clr[g]),
      .flag_o     (flag[g])
    );
  end

  assign irq_o = |(flag & en);

  always_comb begin
    stat_o                           = '0;
    stat_o[IRQ_BIT]                  = irq_o;
    stat_o[FLAG_LSB +: N_SRC]        = flag;
    pwr_o                            = '0;
    pwr_o[VLD_BIT]                   = ~low_seen;
  end

  assert_irq_needs_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat_o[FLAG_LSB +: N_SRC] != '0));
  assert_af_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_o[VLD_BIT] |-> !stat_o[FLAG_LSB + SRC_ALM]);
  assert_alm_blocked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_o[VLD_BIT] && !rd_pwr_i) |=> !stat_o[FLAG_LSB + SRC_ALM]);
endmodule

// File: tb/rtc_irq_flags_bench.sv
module rtc_irq_flags_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 0, clk_dis = 0, upd = 0, alm = 0, tap = 0;
  logic ue = 0, ae = 0, pe = 0, vlow = 0, rds = 0, rdp = 0;
  logic       irq;
  logic [7:0] stat, pwr;

  always #5 clk = ~clk;

  rtc_irq_flags u_rtc_irq_flags (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .clk_dis_i(clk_dis),
    .upd_evt_i(upd), .alm_evt_i(alm), .tap_i(tap),
    .upd_en_i(ue), .alm_en_i(ae), .per_en_i(pe),
    .vlow_i(vlow), .rd_stat_i(rds), .rd_pwr_i(rdp),
    .irq_o(irq), .stat_o(stat), .pwr_o(pwr)
  );

  typedef struct {
    logic [7:0] stat;
    logic [7:0] pwr;
    string      tag;
  } item_t;

  item_t q[$];
  int checks = 0, failures = 0;
  bit done = 0;

  // reference state
  bit m_uf = 0, m_af = 0, m_pf = 0, m_low = 0, m_tap = 0;

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (stat !== it.stat || pwr !== it.pwr || irq !== it.stat[7]) begin
        failures++;
        $display("FAIL %s stat=%h pwr=%h irq=%b expected stat=%h pwr=%h irq=%b",
                 it.tag, stat, pwr, irq, it.stat, it.pwr, it.stat[7]);
      end
    end
  end

  // drive one cycle, model the next state, queue expectation
  task automatic step(input bit s_srst, s_dis, s_upd, s_alm, s_tap,
                      s_ue, s_ae, s_pe, s_vlow, s_rds, s_rdp, input string tag);
    item_t it;
    bit low_n, irq_n;
    @(negedge clk);
    soft_rst = s_srst; clk_dis = s_dis; upd = s_upd; alm = s_alm; tap = s_tap;
    ue = s_ue; ae = s_ae; pe = s_pe; vlow = s_vlow; rds = s_rds; rdp = s_rdp;
    low_n = s_rdp ? s_vlow : (m_low | s_vlow);
    m_uf  = (s_srst | s_dis) ? 1'b0 : (s_upd | (m_uf & ~s_rds));
    m_pf  = (s_srst | s_dis) ? 1'b0 : ((s_tap != m_tap) | (m_pf & ~s_rds));
    m_af  = low_n ? 1'b0 : (s_alm | (m_af & ~s_rds));
    m_tap = s_tap;
    m_low = low_n;
    irq_n = (s_ue & m_uf) | (s_ae & m_af) | (s_pe & m_pf);
    it.stat = {irq_n, m_pf, m_af, m_uf, 4'b0000};
    it.pwr  = {~m_low, 7'b0000000};
    it.tag  = tag;
    @(posedge clk);
    q.push_back(it);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    //    srst dis upd alm tap ue ae pe vlow rds rdp
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 reset state");
    step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R2 update flag, irq masked");
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R5 update enable raises irq");
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 1, 0, "R6 read clears update flag");
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R3 alarm flag, irq masked");
    step(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R5 alarm enable raises irq");
    step(0, 0, 0, 0, 1, 0, 1, 1, 0, 0, 0, "R4 rising tap sets periodic");
    step(0, 0, 0, 0, 1, 0, 1, 1, 0, 1, 0, "R6 read clears all, steady tap");
    step(0, 0, 0, 0, 1, 0, 1, 1, 0, 0, 0, "R4 steady tap keeps periodic clear");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 falling tap sets periodic");
    step(0, 0, 1, 0, 0, 0, 0, 1, 0, 1, 0, "R7 event beats same-cycle read");
    step(0, 0, 1, 1, 0, 1, 1, 0, 0, 0, 0, "R5 update and alarm enables");
    step(0, 1, 1, 0, 1, 1, 1, 0, 0, 0, 0, "R8 disable clears update, keeps alarm");
    step(1, 0, 1, 0, 0, 1, 0, 1, 0, 0, 0, "R8 soft reset blocks update and periodic");
    step(0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0, "R9 low supply clears valid, R11 alarm dropped");
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R9 valid stays low after sense falls");
    step(0, 0, 0, 1, 0, 0, 1, 0, 0, 0, 0, "R11 alarm ignored while invalid");
    step(0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 1, "R10 read with sense high stays low");
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1, "R10 read with sense low re-arms");
    step(0, 0, 0, 1, 0, 0, 1, 0, 0, 0, 0, "R3 alarm sets once valid");
    step(0, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0, "R12 all flags set, unused bits zero");
    step(0, 0, 0, 0, 1, 1, 1, 1, 0, 0, 0, "R5 all enables with all flags");
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule